// File: doc/BRIEF.md
# Serial Management Word Shifter

This block is the master side of a two-wire management link of the MDC/MDIO kind. Software hands it one 32-bit word at a time through a small register port. Each word goes out serially, most significant bit first, on the data pin, paced by a management clock that the block divides down from its own clock. Building a whole frame is left to software. It sends an all-ones word as the preamble, then a command word, then an all-zero word that lets the line settle back to idle.

A write command word has the pattern 0x59020000, with the register address in bits 22:18 and the payload in bits 15:0. A read command word has the pattern 0x69020000, with the address in the same place. When the 2-bit opcode in bits 29:28 of a word reads 2'b10, the engine lets go of the data pin from the turnaround bits onward. It then collects the 16 bits that the far end returns, and these appear in the low half of the status word.

The status word carries a busy flag in bit 31. Software polls it before sending the next word.

Top module: `mdio_word_master`

## Requirements
- R1: While reset is held and right after it, `status` reads 0, `mdc` is low and `mdio_oe` is low.
- R2: A write pulse with `reg_addr` = 0 (the generate register) while idle starts a shift of `wr_data`. `status[31]` reads 1 from the next cycle for exactly 33·DIV clock cycles: 32 bit periods plus one trailing MDC period.
- R3: `mdc` toggles only while busy. Each MDC period is DIV clocks long, with the low half first and then HALF = DIV/2 clocks high.
- R4: Bit i of the frame (i = 0 carries word bit 31) is presented during MDC period i. `mdio_o` changes only at the start of the shift and together with falling edges of `mdc`, and never while `mdc` stays high.
- R5: A word whose bits 29:28 equal 2'b10 is a read frame. For a read frame `mdio_oe` is high for bits 0..13 and low from bit 14 (turnaround) onward. Every other word drives all 32 bits. `mdio_oe` is low in the trailing period and whenever idle.
- R6: In a read frame, `mdio_i` is sampled on the clock edge where `mdc` rises in bits 16..31. After the frame, `status[15:0]` holds them with the bit-16 sample in bit 15.
- R7: A write to the generate register while busy is ignored. The frame under way is neither changed nor lengthened.
- R8: A frame that is not a read leaves `status[15:0]` unchanged.
- R9: A write pulse with `reg_addr` = 1 (the status register) is ignored and does not start a shift.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = generate register, 1 = status register |
| wr_data | input | 32 | Word to shift out |
| status | output | 32 | {busy, 15'b0, last read data} |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Serial data out |
| mdio_oe | output | 1 | Output enable for the data pin |
| mdio_i | input | 1 | Serial data in |

## Verification
Two situations are hard to reach from the ports. The first is a read frame in which the far end must answer in step with MDC. The second is a stray generate write that lands in the middle of a frame. The bench models the far end by counting MDC rising edges and presenting the matching bit of a chosen response word on `mdio_i`, so the captured half-word can be predicted. In one frame the bench also fires a generate write part-way through the shift. The scoreboard then shows whether the bit stream or the frame length was disturbed.

// File: rtl/mdio_word_master.sv
module mdio_word_master #(
  parameter int DIV = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        reg_addr,
  input  logic [31:0] wr_data,
  output logic [31:0] status,
  output logic        mdc,
  output logic        mdio_o,
  output logic        mdio_oe,
  input  logic        mdio_i
);
  localparam int HALF = DIV / 2;
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] DIV_LAST = CW'(DIV - 1);
  localparam logic [CW-1:0] RISE_AT = CW'(HALF - 1);

  logic          busy;
  logic          rd_frame;
  logic [CW-1:0] div_cnt;
  logic [5:0]    bit_idx;
  logic [31:0]   shreg;
  logic [15:0]   rd_word;
  logic          mdc_q;

  wire launch = wr_en && (reg_addr == 1'b0) && !busy;
  wire in_bits = busy && (bit_idx < 6'd32);
  wire released = rd_frame && (bit_idx >= 6'd14);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rd_frame <= 1'b0;
      div_cnt  <= '0;
      bit_idx  <= '0;
      shreg    <= '0;
      rd_word  <= '0;
      mdc_q    <= 1'b0;
    end else if (!busy) begin
      mdc_q <= 1'b0;
      if (launch) begin
        busy     <= 1'b1;
        shreg    <= wr_data;
        rd_frame <= (wr_data[29:28] == 2'b10);
        bit_idx  <= '0;
        div_cnt  <= '0;
      end
    end else begin
      if (div_cnt == DIV_LAST) begin
        div_cnt <= '0;
        mdc_q   <= 1'b0;
        if (bit_idx == 6'd32) begin
          busy <= 1'b0;
        end else begin
          bit_idx <= bit_idx + 6'd1;
          shreg   <= {shreg[30:0], 1'b0};
        end
      end else begin
        div_cnt <= div_cnt + CW'(1);
        if (div_cnt == RISE_AT) mdc_q <= 1'b1;
      end
      if (div_cnt == RISE_AT && rd_frame && bit_idx >= 6'd16 && bit_idx < 6'd32)
        rd_word <= {rd_word[14:0], mdio_i};
    end
  end

  assign mdc     = mdc_q;
  assign mdio_oe = in_bits && !released;
  assign mdio_o  = mdio_oe ? shreg[31] : 1'b0;
  assign status  = {busy, 15'b0, rd_word};
endmodule

module mdio_word_master_chk #(
  parameter int DIV = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        reg_addr,
  input logic        busy,
  input logic        rd_frame,
  input logic [5:0]  bit_idx,
  input logic [15:0] rd_word,
  input logic        mdc,
  input logic        mdio_o,
  input logic        mdio_oe
);
  int run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_cnt <= 0;
    else if (busy) run_cnt <= run_cnt + 1;
    else run_cnt <= 0;
  end

  assert_mdc_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mdc);
  assert_launch_src_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en && reg_addr == 1'b0));
  assert_frame_len_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> run_cnt < 33 * DIV);
  assert_hold_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc && $past(mdc)) |-> $stable(mdio_o));
  assert_oe_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mdio_oe |-> busy);
  assert_turnaround_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_frame && bit_idx >= 6'd14) |-> !mdio_oe);
  assert_keep_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && rd_frame) |=> $stable(rd_word));
endmodule

bind mdio_word_master mdio_word_master_chk #(.DIV(DIV)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
  .busy(busy), .rd_frame(rd_frame), .bit_idx(bit_idx), .rd_word(rd_word),
  .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
);

// File: tb/mdio_word_master_tb.sv
module mdio_word_master_tb;
  localparam int DIV = 8;
  localparam int HALF = DIV / 2;

  logic clk = 0, rst_n = 0, wr_en = 0, reg_addr = 0;
  logic [31:0] wr_data = '0;
  logic [31:0] status;
  logic mdc, mdio_o, mdio_oe, mdio_i;

  int checks = 0, fails = 0, cycles = 0;
  logic [1:0] exp_q[$];
  logic [31:0] phy_word = '0;
  int rise_cnt = 0;
  logic mdc_prev = 0, busy_prev = 0, o_prev = 0;
  int since_rise = 0, high_len = 0;

  always #10 clk = ~clk;

  mdio_word_master #(.DIV(DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
    .wr_data(wr_data), .status(status), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i));

  assign mdio_i = (rise_cnt < 32) ? phy_word[31 - rise_cnt] : 1'b0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    cycles++;
    if (status[31] && !busy_prev) begin
      rise_cnt = 0;
      since_rise = 0;
    end
    if (mdc && mdc_prev && mdio_o != o_prev)
      check(0, "R4 mdio_o moved while mdc high", {31'b0, mdio_o}, {31'b0, o_prev});
    if (mdc) high_len++;
    if (!mdc && mdc_prev) begin
      check(high_len == HALF, "R3 high time", high_len, HALF);
      high_len = 0;
    end
    since_rise++;
    if (mdc && !mdc_prev) begin
      if (rise_cnt > 0) check(since_rise == DIV, "R3 period", since_rise, DIV);
      since_rise = 0;
      high_len = 1;
      if (exp_q.size() == 0) check(0, "R4 unexpected bit", {30'b0, mdio_oe, mdio_o}, 0);
      else begin
        logic [1:0] e;
        e = exp_q.pop_front();
        check({mdio_oe, mdio_o} == e, "R4/R5 bit", {30'b0, mdio_oe, mdio_o}, {30'b0, e});
      end
      rise_cnt++;
    end
    mdc_prev = mdc;
    busy_prev = status[31];
    o_prev = mdio_o;
  end

  always @(negedge clk) begin
    if (cycles > 100000) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic send(input logic [31:0] w, input logic [31:0] phy, input bit stray);
    bit rd;
    int n;
    rd = (w[29:28] == 2'b10);
    for (int i = 0; i < 32; i++) begin
      bit oe;
      oe = !(rd && i >= 14);
      exp_q.push_back({oe, oe ? w[31 - i] : 1'b0});
    end
    exp_q.push_back(2'b00);
    phy_word = phy;
    @(negedge clk);
    wr_en = 1; reg_addr = 0; wr_data = w;
    @(negedge clk);
    wr_en = 0;
    n = 0;
    while (status[31] && n < 1000) begin
      n++;
      if (stray && n == 40) begin
        wr_en = 1; reg_addr = 0; wr_data = 32'h0000_0000;
      end else wr_en = 0;
      @(negedge clk);
    end
    wr_en = 0;
    check(n == 33 * DIV, stray ? "R7 length with stray write" : "R2 busy length", n, 33 * DIV);
    check(exp_q.size() == 0, "R4 all bits seen", exp_q.size(), 0);
    exp_q.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(status == 0 && !mdc && !mdio_oe, "R1 reset state", status, 0);
    rst_n = 1;
    @(negedge clk);
    check(status == 0 && !mdc && !mdio_oe, "R1 after reset", status, 0);

    send(32'hFFFF_FFFF, 32'h0, 0);
    send(32'h5902_0000 | (32'd5 << 18) | 32'h0000_BEEF, 32'h0, 0);
    check(status[15:0] == 16'h0000, "R8 write frame keeps data", status, 0);
    send(32'h0, 32'h0, 0);

    send(32'hFFFF_FFFF, 32'h0, 0);
    send(32'h6902_0000 | (32'd31 << 18), 32'hFFFF_A5C3, 0);
    check(status[15:0] == 16'hA5C3, "R6 read data", status[15:0], 16'hA5C3);
    send(32'h0, 32'hFFFF_FFFF, 0);
    check(status[15:0] == 16'hA5C3, "R8 idle word keeps data", status[15:0], 16'hA5C3);

    send(32'h6902_0000 | (32'd2 << 18), 32'h0000_3C5A, 1);
    check(status[15:0] == 16'h3C5A, "R6/R7 read with stray write", status[15:0], 16'h3C5A);

    send(32'h5902_0000 | 32'h0000_1234, 32'hFFFF_FFFF, 0);
    check(status[15:0] == 16'h3C5A, "R8 write frame after read", status[15:0], 16'h3C5A);

    @(negedge clk);
    wr_en = 1; reg_addr = 1; wr_data = 32'hFFFF_FFFF;
    @(negedge clk);
    wr_en = 0;
    check(status == 32'h0000_3C5A, "R9 status write ignored", status, 32'h0000_3C5A);
    repeat (DIV) @(negedge clk);
    check(!mdc && !mdio_oe && !status[31], "R9 no shift started", {29'b0, mdc, mdio_oe, status[31]}, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule